// File: doc/BRIEF.md
# Nine-bit UART receive holding register with error flags

This block is the receive-side buffer and status logic of a UART. A receive shifter hands it finished frames as a one-cycle strobe. Each frame carries a data byte, an optional ninth bit, and noise and framing-error indications. The block holds the accepted frame in a data register and a separate ninth-bit field. In 9-bit mode the ninth-bit field is read as the bit just above the most significant data bit. The block tracks whether the buffer is full and keeps three sticky error flags: overrun, noise and framing.

The error flags clear through a two-step software sequence. First a status read must see the flag set. A later data-register read then clears that flag. The data read also releases the buffer, so the next frame can overwrite both the data byte and the ninth bit. Software must therefore read the ninth bit before it reads the data register. Each error flag has its own interrupt enable, and the gated flags are combined into one registered interrupt request. All enables reset to 0. With an enable at 0, its flag can only be polled.

Top module: `uart_rx_hold`

## Requirements
- R1: After a synchronous reset, the outputs are as follows: `rx_data_o` is 0, `rx_bit9_o` is 0, `rx_full_o` is 0, `err_flags_o` is 0 and `irq_o` is 0. All three interrupt enables are 0.
- R2: A frame strobe while the buffer is empty is accepted. On the next clock, `rx_data_o` shows the frame byte, `rx_bit9_o` shows the frame's ninth bit, and `rx_full_o` is 1.
- R3: When `nine_bit_mode_i` is 0, an accepted frame stores 0 in the ninth-bit field, whatever the value of `frm_bit9_i`.
- R4: A pulse on `data_rd_i` clears `rx_full_o` on the next clock and leaves `rx_data_o` unchanged. A frame strobe in the same cycle as a data read is accepted, and no overrun is raised.
- R5: A frame strobe while the buffer is full, with no data read in that cycle, sets the overrun flag (`err_flags_o` bit 0). The held byte and ninth bit are kept. The new frame is discarded, including its noise and framing indications.
- R6: An accepted frame with `frm_noise_i` set sets the noise flag (bit 1). An accepted frame with `frm_ferr_i` set sets the framing flag (bit 2). The flag appears on the same clock as the frame data.
- R7: A flag that was 1 during a `status_rd_i` cycle clears on the clock that follows the next `data_rd_i`. A flag that sets after that status read stays set through that data read.
- R8: A data read that is not preceded by a status read seeing the flag set leaves every error flag unchanged.
- R9: `ctl_wr_i` loads the enables from `ctl_wdata_i`. Bit 0 enables overrun, bit 1 enables noise and bit 2 enables framing. `irq_o` equals the OR of each flag ANDed with its enable. It is registered, so it changes on the same clock as the flags and enables it depends on.
- R10: A flag whose enable is 0 is visible in `err_flags_o` but does not assert `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid_i | input | 1 | One-cycle strobe: a frame is complete |
| frm_data_i | input | DATA_W | Frame data byte |
| frm_bit9_i | input | 1 | Frame ninth bit |
| frm_noise_i | input | 1 | Noise was detected in the frame |
| frm_ferr_i | input | 1 | Framing error in the frame |
| nine_bit_mode_i | input | 1 | 1 = 9-bit frames, 0 = 8-bit frames |
| status_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| ctl_wr_i | input | 1 | Interrupt enable write strobe |
| ctl_wdata_i | input | 3 | Enables: bit 0 overrun, bit 1 noise, bit 2 framing |
| rx_data_o | output | DATA_W | Held data byte |
| rx_bit9_o | output | 1 | Held ninth bit |
| rx_full_o | output | 1 | Buffer holds an unread frame |
| err_flags_o | output | 3 | Flags: bit 0 overrun, bit 1 noise, bit 2 framing |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that each input strobe lasts a single cycle and is either 0 or 1. They also assume that the frame fields are only meaningful while `frm_valid_i` is high. The bench drives every strobe for exactly one clock, changes inputs only on the falling edge, and returns all strobes to 0 between steps. It also drives a data read together with a frame strobe on purpose, and the assertions cover that case as an accepted frame, not as an overrun.

// File: rtl/uart_rx_hold_pkg.sv
package uart_rx_hold_pkg;
  localparam int ERR_W   = 3;
  localparam int IDX_OVR = 0;
  localparam int IDX_NSE = 1;
  localparam int IDX_FRM = 2;
endpackage

// File: rtl/rxh_buffer.sv
module rxh_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_bit9,
  input  logic              nine_mode,
  input  logic              data_rd,
  output logic              accept,
  output logic              overrun_evt,
  output logic [DATA_W-1:0] data_q,
  output logic              bit9_q,
  output logic              full_q
);
  // The buffer is free if it is empty or is being read in this same cycle.
  assign accept      = frm_valid && (!full_q || data_rd);
  assign overrun_evt = frm_valid && full_q && !data_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      bit9_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (accept) begin
        data_q <= frm_data;
        bit9_q <= nine_mode & frm_bit9;
        full_q <= 1'b1;
      end else if (data_rd) begin
        full_q <= 1'b0;
      end
    end
  end

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && full_q && !data_rd) |=> ($stable(data_q) && $stable(bit9_q)));

  // R4
  full_release_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !frm_valid) |=> !full_q);

  // R3
  bit9_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !nine_mode && (!full_q || data_rd)) |=> !bit9_q);
endmodule

// File: rtl/rxh_flag.sv
module rxh_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic status_rd,
  input  logic data_rd,
  output logic flag_q,
  output logic flag_nxt
);
  logic arm_q;
  logic arm_nxt;
  logic clr;

  assign clr      = data_rd && arm_q;
  assign flag_nxt = set_evt ? 1'b1 : (clr ? 1'b0 : flag_q);

  always_comb begin
    arm_nxt = arm_q;
    if (status_rd)    arm_nxt = flag_q && !clr;
    else if (data_rd) arm_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      arm_q  <= arm_nxt;
    end
  end

  // R8
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(data_rd));

  // R7
  arm_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    arm_q |-> flag_q);
endmodule

// File: rtl/rxh_irq.sv
module rxh_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctl_wr,
  input  logic [N-1:0] ctl_wdata,
  input  logic [N-1:0] flag_nxt,
  input  logic [N-1:0] flag_q,
  output logic         irq_q
);
  logic [N-1:0] en_q;
  logic [N-1:0] en_nxt;

  assign en_nxt = ctl_wr ? ctl_wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      irq_q <= |(flag_nxt & en_nxt);
    end
  end

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(flag_q & en_q));

  // R1
  en_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (en_q == '0 && !irq_q));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq_q);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_hold_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic              frm_bit9_i,
  input  logic              frm_noise_i,
  input  logic              frm_ferr_i,
  input  logic              nine_bit_mode_i,
  input  logic              status_rd_i,
  input  logic              data_rd_i,
  input  logic              ctl_wr_i,
  input  logic [ERR_W-1:0]  ctl_wdata_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              rx_full_o,
  output logic [ERR_W-1:0]  err_flags_o,
  output logic              irq_o
);
  logic             accept;
  logic             overrun_evt;
  logic [ERR_W-1:0] set_vec;
  logic [ERR_W-1:0] flag_q;
  logic [ERR_W-1:0] flag_nxt;

  rxh_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk         (clk),
    .rst         (rst),
    .frm_valid   (frm_valid_i),
    .frm_data    (frm_data_i),
    .frm_bit9    (frm_bit9_i),
    .nine_mode   (nine_bit_mode_i),
    .data_rd     (data_rd_i),
    .accept      (accept),
    .overrun_evt (overrun_evt),
    .data_q      (rx_data_o),
    .bit9_q      (rx_bit9_o),
    .full_q      (rx_full_o)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[IDX_OVR] = overrun_evt;
    set_vec[IDX_NSE] = accept && frm_noise_i;
    set_vec[IDX_FRM] = accept && frm_ferr_i;
  end

  for (genvar g = 0; g < ERR_W; g++) begin : g_flag
    rxh_flag u_flag (
      .clk       (clk),
      .rst       (rst),
      .set_evt   (set_vec[g]),
      .status_rd (status_rd_i),
      .data_rd   (data_rd_i),
      .flag_q    (flag_q[g]),
      .flag_nxt  (flag_nxt[g])
    );
  end

  rxh_irq #(.N(ERR_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr_i),
    .ctl_wdata (ctl_wdata_i),
    .flag_nxt  (flag_nxt),
    .flag_q    (flag_q),
    .irq_q     (irq_o)
  );

  assign err_flags_o = flag_q;

  // R5
  ovr_only_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flags_o[IDX_OVR]) |-> ($past(rx_full_o) && $past(frm_valid_i)));

  // R2
  accept_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid_i && !rx_full_o) |=> rx_full_o);
endmodule

// File: tb/uart_rx_hold_tb.sv
module uart_rx_hold_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       frm_valid_i, frm_bit9_i, frm_noise_i, frm_ferr_i;
  logic [7:0] frm_data_i;
  logic       nine_bit_mode_i, status_rd_i, data_rd_i, ctl_wr_i;
  logic [2:0] ctl_wdata_i;
  logic [7:0] rx_data_o;
  logic       rx_bit9_o, rx_full_o, irq_o;
  logic [2:0] err_flags_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uart_rx_hold #(.DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .frm_valid_i(frm_valid_i), .frm_data_i(frm_data_i),
    .frm_bit9_i(frm_bit9_i), .frm_noise_i(frm_noise_i), .frm_ferr_i(frm_ferr_i),
    .nine_bit_mode_i(nine_bit_mode_i), .status_rd_i(status_rd_i),
    .data_rd_i(data_rd_i), .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .rx_data_o(rx_data_o), .rx_bit9_o(rx_bit9_o), .rx_full_o(rx_full_o),
    .err_flags_o(err_flags_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    frm_valid_i = 0; frm_bit9_i = 0; frm_noise_i = 0; frm_ferr_i = 0;
    frm_data_i = '0; status_rd_i = 0; data_rd_i = 0; ctl_wr_i = 0;
  endtask

  // One-cycle strobe; on return the outputs of that clock are settled.
  task automatic frame(input logic [7:0] d, input logic b9, input logic nse,
                       input logic fer, input logic rd);
    @(negedge clk);
    frm_valid_i = 1; frm_data_i = d; frm_bit9_i = b9;
    frm_noise_i = nse; frm_ferr_i = fer; data_rd_i = rd;
    @(negedge clk);
    idle();
  endtask

  task automatic status_read();
    @(negedge clk); status_rd_i = 1; @(negedge clk); idle();
  endtask

  task automatic data_read();
    @(negedge clk); data_rd_i = 1; @(negedge clk); idle();
  endtask

  task automatic ctl_write(input logic [2:0] v);
    @(negedge clk); ctl_wr_i = 1; ctl_wdata_i = v; @(negedge clk); idle();
  endtask

  task automatic t_reset();
    check("R1 data", 32'(rx_data_o), 0);
    check("R1 bit9", 32'(rx_bit9_o), 0);
    check("R1 full", 32'(rx_full_o), 0);
    check("R1 flags", 32'(err_flags_o), 0);
    check("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_basic();
    nine_bit_mode_i = 1;
    frame(8'hA5, 1, 0, 0, 0);
    check("R2 data", 32'(rx_data_o), 32'hA5);
    check("R2 bit9", 32'(rx_bit9_o), 1);
    check("R2 full", 32'(rx_full_o), 1);
    data_read();
    check("R4 full released", 32'(rx_full_o), 0);
    check("R4 data kept", 32'(rx_data_o), 32'hA5);
  endtask

  task automatic t_8bit();
    nine_bit_mode_i = 0;
    frame(8'h3C, 1, 0, 0, 0);
    check("R3 bit9 zero", 32'(rx_bit9_o), 0);
    check("R3 data", 32'(rx_data_o), 32'h3C);
    data_read();
    nine_bit_mode_i = 1;
  endtask

  task automatic t_overrun();
    frame(8'h11, 1, 0, 0, 0);
    frame(8'h22, 0, 1, 1, 0);
    check("R5 ovr set", 32'(err_flags_o), 32'b001);
    check("R5 data kept", 32'(rx_data_o), 32'h11);
    check("R5 bit9 kept", 32'(rx_bit9_o), 1);
    status_read();
    data_read();
    check("R7 ovr cleared", 32'(err_flags_o), 0);
    check("R7 full", 32'(rx_full_o), 0);
  endtask

  task automatic t_noise_frame();
    frame(8'h77, 0, 1, 1, 0);
    check("R6 noise+framing", 32'(err_flags_o), 32'b110);
    data_read();
    check("R8 flags unchanged", 32'(err_flags_o), 32'b110);
    check("R8 full released", 32'(rx_full_o), 0);
    status_read();
    data_read();
    check("R7 cleared", 32'(err_flags_o), 0);
  endtask

  task automatic t_late_flag();
    frame(8'h01, 0, 1, 0, 0);
    status_read();
    frame(8'h02, 0, 0, 0, 0);
    check("R5 ovr after arm", 32'(err_flags_o), 32'b011);
    data_read();
    check("R7 late flag kept", 32'(err_flags_o), 32'b001);
    status_read();
    data_read();
    check("R7 second clear", 32'(err_flags_o), 0);
  endtask

  task automatic t_same_cycle();
    frame(8'h55, 0, 0, 0, 0);
    frame(8'h66, 1, 0, 0, 1);
    check("R4 same-cycle data", 32'(rx_data_o), 32'h66);
    check("R4 same-cycle full", 32'(rx_full_o), 1);
    check("R4 no overrun", 32'(err_flags_o), 0);
    data_read();
  endtask

  task automatic t_irq();
    frame(8'h10, 0, 0, 0, 0);
    frame(8'h20, 0, 0, 0, 0);
    check("R10 ovr polled", 32'(err_flags_o), 32'b001);
    check("R10 no irq", 32'(irq_o), 0);
    ctl_write(3'b001);
    check("R9 ovr irq", 32'(irq_o), 1);
    ctl_write(3'b110);
    check("R10 ovr masked", 32'(irq_o), 0);
    status_read();
    data_read();
    frame(8'h30, 0, 1, 0, 0);
    check("R9 noise irq same clock", 32'(irq_o), 1);
    status_read();
    data_read();
    check("R9 irq drops with flag", 32'(irq_o), 0);
  endtask

  initial begin
    idle();
    ctl_wdata_i = '0;
    nine_bit_mode_i = 1;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_8bit();
    t_overrun();
    t_noise_frame();
    t_late_flag();
    t_same_cycle();
    t_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule